// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block handles interrupts for a small processor. Up to 32 numbered sources each deliver one-cycle raise pulses. For every source the block keeps three bits: a raised flag, an enable bit and a pending bit. The raised flag latches on every raise, so software that does not use interrupts can still poll it. A pending request is recorded only when the source is enabled at the moment of the raise. Once the global interrupt enable is set and a request has been pending for a fixed latency, the block picks the lowest-numbered pending source. It then presents a vector address, equal to the source number times the vector stride, on a request/acknowledge handshake to the CPU.

When the CPU acknowledges, the block clears the global enable and clears both the pending bit and the raised flag of the source being serviced. A return-from-interrupt pulse sets the global enable again. If the lowest pending source has had its enable removed since it was raised, the block discards that entry at selection time and issues no vector for it. Source number 0 is reserved for reset and can never be raised. Software can clear any raised flag, together with its pending request, by writing a mask with a 1 in that source's bit.

Top module: `prio_vic`

## Requirements
- R1: Directly after reset, all raised flags, pending bits and enable bits are 0, global enable is 0 and no request is presented.
- R2: A raise pulse on source k (k not 0, k not already pending) sets raised bit k on the next clock edge, whether or not source k is enabled.
- R3: Pending bit k is set by a raise only if enable bit k was 1 on the clock edge that samples the raise. A raise on a disabled source leaves pending bit k at 0.
- R4: A raise on source 0 has no effect: raised bit 0 and pending bit 0 stay 0 even when enable bit 0 is written as 1.
- R5: A raise on a source that is already pending is ignored. Exactly one vector is issued for that source.
- R6: When several sources are pending, vectors are issued in ascending source-number order. The lowest number is serviced first.
- R7: While global enable is 0, no request is presented, however long sources stay pending.
- R8: With global enable set and the controller idle, the request rises on the third clock edge after the edge that samples a raise. This is a latency of two wait cycles.
- R9: If the lowest pending source has since been disabled, its pending bit is cleared at selection, no vector is issued for it and its raised flag stays 1. Selection then continues with the next pending source.
- R10: An acknowledge while the request is high drops the request and clears global enable on the next edge. It also clears that source's pending bit and raised flag. The vector address equals source number × VEC_WORDS (default stride 2, so source 7 gives 14).
- R11: A 1 in bit k of the flag-clear mask clears raised bit k and pending bit k on the next edge. Bits written as 0 are left untouched.
- R12: A return-from-interrupt pulse sets global enable on the next edge.
- R13: Once presented, the request stays high and the vector stays stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_raise_i | input | NUM_SRC | One-cycle raise pulse per source (bit 0 ignored) |
| src_en_we_i | input | 1 | Write strobe for the enable mask |
| src_en_wdata_i | input | NUM_SRC | New enable mask |
| flag_clr_i | input | NUM_SRC | Write-1-to-clear mask for raised flags and pending bits |
| gie_set_i | input | 1 | Set global interrupt enable |
| gie_clr_i | input | 1 | Clear global interrupt enable |
| reti_i | input | 1 | Return from interrupt; sets global enable |
| irq_ack_i | input | 1 | CPU accepts the presented vector |
| gie_o | output | 1 | Global interrupt enable |
| raised_o | output | NUM_SRC | Raised flags |
| pending_o | output | NUM_SRC | Pending bits |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | VADDR_W | Vector address of the presented request |

## Verification
The properties assume that reset is held from time zero for at least one edge and that the acknowledge is only pulsed while a request is visible. They also assume that no flag-clear bit coincides with a raise of the same source; the clear-path property excludes such bits explicitly. The stimulus drives every input on the falling clock edge. It acknowledges only from the monitor after it has seen the request. It never combines a clear and a raise on the same source, and it changes the enable mask only while the global enable is low or the controller is idle.

// File: rtl/vic_pkg.sv
package vic_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_REQ  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raise_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_wdata_i,
  input  logic [N-1:0] clr_mask_i,
  input  logic [N-1:0] ack_clr_i,
  input  logic [N-1:0] drop_clr_i,
  output logic [N-1:0] raised_o,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] en_o
);

  // source 0 is reserved for reset and may never be raised
  localparam logic [N-1:0] RAISE_OK = ~{{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] raise_ok;
  assign raise_ok = raise_i & RAISE_OK;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic raised_q, pend_q, en_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        raised_q <= 1'b0;
        pend_q   <= 1'b0;
        en_q     <= 1'b0;
      end else begin
        if (en_we_i)
          en_q <= en_wdata_i[i];
        if (clr_mask_i[i] || ack_clr_i[i])
          raised_q <= 1'b0;
        if (clr_mask_i[i] || ack_clr_i[i] || drop_clr_i[i])
          pend_q <= 1'b0;
        // a new raise wins over a clear in the same cycle; a raise on a
        // source that is already pending is dropped entirely
        if (raise_ok[i] && !pend_q) begin
          raised_q <= 1'b1;
          if (en_q)
            pend_q <= 1'b1;
        end
      end
    end

    assign raised_o[i] = raised_q;
    assign pend_o[i]   = pend_q;
    assign en_o[i]     = en_q;
  end

endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int N   = 32,
  parameter int IDW = 5
) (
  input  logic [N-1:0]   req_i,
  output logic           found_o,
  output logic [IDW-1:0] idx_o
);

  // lowest index wins: scan from the top so the last hit is the smallest
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDW'(i);
      end
    end
  end

endmodule

// File: rtl/vic_sequencer.sv
module vic_sequencer
  import vic_pkg::*;
#(
  parameter int N         = 32,
  parameter int IDW       = 5,
  parameter int LATENCY   = 2,
  parameter int VEC_WORDS = 2,
  parameter int VADDR_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       en_i,
  input  logic               sel_found_i,
  input  logic [IDW-1:0]     sel_idx_i,
  input  logic               gie_set_i,
  input  logic               gie_clr_i,
  input  logic               reti_i,
  input  logic               ack_i,
  output logic               gie_o,
  output logic               req_o,
  output logic [VADDR_W-1:0] vec_o,
  output logic [N-1:0]       ack_clr_o,
  output logic [N-1:0]       drop_clr_o
);

  localparam int CW = (LATENCY > 1) ? $clog2(LATENCY + 1) : 1;
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  seq_state_e         st_q;
  logic [CW-1:0]      cnt_q;
  logic               gie_q;
  logic               req_q;
  logic [VADDR_W-1:0] vec_q;
  logic [IDW-1:0]     id_q;

  logic accept;
  logic sel_now;
  logic sel_live;

  assign accept   = (st_q == SEQ_REQ) && ack_i;
  assign sel_now  = (st_q == SEQ_WAIT) && gie_q && sel_found_i && (cnt_q == '0);
  assign sel_live = en_i[sel_idx_i];

  assign ack_clr_o  = accept ? (ONE << id_q) : '0;
  assign drop_clr_o = (sel_now && !sel_live) ? (ONE << sel_idx_i) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q <= 1'b0;
    end else begin
      if (gie_set_i || reti_i)
        gie_q <= 1'b1;
      if (gie_clr_i || accept)
        gie_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      req_q <= 1'b0;
      vec_q <= '0;
      id_q  <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: begin
          if (gie_q && sel_found_i) begin
            cnt_q <= CW'(LATENCY - 1);
            st_q  <= SEQ_WAIT;
          end
        end
        SEQ_WAIT: begin
          if (!gie_q || !sel_found_i) begin
            st_q <= SEQ_IDLE;
          end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (sel_live) begin
            req_q <= 1'b1;
            vec_q <= VADDR_W'(32'(sel_idx_i) * VEC_WORDS);
            id_q  <= sel_idx_i;
            st_q  <= SEQ_REQ;
          end else begin
            // stale entry dropped; restart the latency for the next one
            st_q <= SEQ_IDLE;
          end
        end
        SEQ_REQ: begin
          if (ack_i) begin
            req_q <= 1'b0;
            st_q  <= SEQ_IDLE;
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign gie_o = gie_q;
  assign req_o = req_q;
  assign vec_o = vec_q;

endmodule

// File: rtl/prio_vic.sv
module prio_vic
  import vic_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int VEC_WORDS = 2,
  parameter int VADDR_W   = 16,
  parameter int LATENCY   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_raise_i,
  input  logic               src_en_we_i,
  input  logic [NUM_SRC-1:0] src_en_wdata_i,
  input  logic [NUM_SRC-1:0] flag_clr_i,
  input  logic               gie_set_i,
  input  logic               gie_clr_i,
  input  logic               reti_i,
  input  logic               irq_ack_i,
  output logic               gie_o,
  output logic [NUM_SRC-1:0] raised_o,
  output logic [NUM_SRC-1:0] pending_o,
  output logic               irq_req_o,
  output logic [VADDR_W-1:0] irq_vec_o
);

  localparam int IDW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] src_en;
  logic [NUM_SRC-1:0] ack_clr;
  logic [NUM_SRC-1:0] drop_clr;
  logic               sel_found;
  logic [IDW-1:0]     sel_idx;

  vic_src_bank #(.N(NUM_SRC)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .raise_i    (src_raise_i),
    .en_we_i    (src_en_we_i),
    .en_wdata_i (src_en_wdata_i),
    .clr_mask_i (flag_clr_i),
    .ack_clr_i  (ack_clr),
    .drop_clr_i (drop_clr),
    .raised_o   (raised_o),
    .pend_o     (pending_o),
    .en_o       (src_en)
  );

  vic_prio_enc #(.N(NUM_SRC), .IDW(IDW)) u_enc (
    .req_i   (pending_o),
    .found_o (sel_found),
    .idx_o   (sel_idx)
  );

  vic_sequencer #(
    .N         (NUM_SRC),
    .IDW       (IDW),
    .LATENCY   (LATENCY),
    .VEC_WORDS (VEC_WORDS),
    .VADDR_W   (VADDR_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .en_i        (src_en),
    .sel_found_i (sel_found),
    .sel_idx_i   (sel_idx),
    .gie_set_i   (gie_set_i),
    .gie_clr_i   (gie_clr_i),
    .reti_i      (reti_i),
    .ack_i       (irq_ack_i),
    .gie_o       (gie_o),
    .req_o       (irq_req_o),
    .vec_o       (irq_vec_o),
    .ack_clr_o   (ack_clr),
    .drop_clr_o  (drop_clr)
  );

endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int N       = 32,
  parameter int VADDR_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [N-1:0]       raise,
  input logic [N-1:0]       clr,
  input logic [N-1:0]       en,
  input logic [N-1:0]       raised,
  input logic [N-1:0]       pend,
  input logic               gie,
  input logic               req,
  input logic               ack,
  input logic [VADDR_W-1:0] vec
);

  localparam logic [N-1:0] NZ = ~{{(N-1){1'b0}}, 1'b1};

  logic armed_q;
  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  // R2: a fresh raise always latches the flag
  a_r2_raise_latches: assert property (@(posedge clk) disable iff (rst || !armed_q)
    ((raised & $past(raise & ~pend & NZ)) == $past(raise & ~pend & NZ)));

  // R3: pending only appears where the enable was set
  a_r3_pend_needs_en: assert property (@(posedge clk) disable iff (rst || !armed_q)
    ((pend & ~$past(pend) & ~$past(en)) == '0));

  // R7: request only rises while global enable was on
  a_r7_gie_gates: assert property (@(posedge clk) disable iff (rst || !armed_q)
    $rose(req) |-> $past(gie));

  // R10: acceptance drops request and global enable
  a_r10_accept_clears: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (req && ack) |=> (!req && !gie));

  // R11: write-1 clear empties flag and pending
  a_r11_w1c: assert property (@(posedge clk) disable iff (rst || !armed_q)
    ((clr & ~raise) != '0) |=> (((raised | pend) & $past(clr & ~raise)) == '0));

  // R13: request and vector hold until acknowledged
  a_r13_hold: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (req && !ack) |=> (req && $stable(vec)));

endmodule

bind prio_vic vic_checker #(.N(NUM_SRC), .VADDR_W(VADDR_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .raise  (src_raise_i),
  .clr    (flag_clr_i),
  .en     (src_en),
  .raised (raised_o),
  .pend   (pending_o),
  .gie    (gie_o),
  .req    (irq_req_o),
  .ack    (irq_ack_i),
  .vec    (irq_vec_o)
);

// File: tb/prio_vic_tb.sv
module prio_vic_tb;

  localparam int N     = 32;
  localparam int VW    = 16;
  localparam int VSTEP = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  src_raise_i = '0;
  logic          src_en_we_i = 1'b0;
  logic [N-1:0]  src_en_wdata_i = '0;
  logic [N-1:0]  flag_clr_i = '0;
  logic          gie_set_i = 1'b0;
  logic          gie_clr_i = 1'b0;
  logic          reti_i = 1'b0;
  logic          irq_ack_i = 1'b0;
  logic          gie_o;
  logic [N-1:0]  raised_o;
  logic [N-1:0]  pending_o;
  logic          irq_req_o;
  logic [VW-1:0] irq_vec_o;

  always #10 clk = ~clk;

  prio_vic u_dut (
    .clk            (clk),
    .rst            (rst),
    .src_raise_i    (src_raise_i),
    .src_en_we_i    (src_en_we_i),
    .src_en_wdata_i (src_en_wdata_i),
    .flag_clr_i     (flag_clr_i),
    .gie_set_i      (gie_set_i),
    .gie_clr_i      (gie_clr_i),
    .reti_i         (reti_i),
    .irq_ack_i      (irq_ack_i),
    .gie_o          (gie_o),
    .raised_o       (raised_o),
    .pending_o      (pending_o),
    .irq_req_o      (irq_req_o),
    .irq_vec_o      (irq_vec_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int acks = 0;
  int raise_cyc = 0;
  bit lat_arm = 1'b0;
  logic [VW-1:0] exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] bit_of(int k);
    return {{(N-1){1'b0}}, 1'b1} << k;
  endfunction

  task automatic raise(logic [N-1:0] m);
    src_raise_i = m;
    raise_cyc = cyc;
    @(negedge clk);
    src_raise_i = '0;
  endtask

  task automatic wr_en(logic [N-1:0] m);
    src_en_we_i = 1'b1; src_en_wdata_i = m;
    @(negedge clk);
    src_en_we_i = 1'b0;
  endtask

  task automatic clr_flags(logic [N-1:0] m);
    flag_clr_i = m;
    @(negedge clk);
    flag_clr_i = '0;
  endtask

  task automatic gie_on();
    gie_set_i = 1'b1; @(negedge clk); gie_set_i = 1'b0;
  endtask

  task automatic gie_off();
    gie_clr_i = 1'b1; @(negedge clk); gie_clr_i = 1'b0;
  endtask

  task automatic do_reti();
    reti_i = 1'b1; @(negedge clk); reti_i = 1'b0;
  endtask

  task automatic wait_acks(int target);
    while (acks < target) @(negedge clk);
  endtask

  // monitor: pops expected vectors and acknowledges requests
  initial begin : monitor
    logic [VW-1:0] v0;
    logic [VW-1:0] ve;
    int id;
    forever begin
      @(negedge clk);
      if (!rst && irq_req_o && !irq_ack_i) begin
        if (lat_arm) begin
          lat_arm = 1'b0;
          chk("R8 latency", cyc - raise_cyc, 4);
        end
        v0 = irq_vec_o;
        repeat (2) begin
          @(negedge clk);
          chk("R13 hold", {irq_req_o, irq_vec_o}, {1'b1, v0});
        end
        if (exp_q.size() == 0) begin
          chk("R6 unexpected vector", v0, 16'hFFFF);
        end else begin
          ve = exp_q.pop_front();
          chk("R6 R10 vector order/value", v0, ve);
        end
        id = int'(v0) / VSTEP;
        irq_ack_i = 1'b1;
        @(negedge clk);
        irq_ack_i = 1'b0;
        chk("R10 request dropped", irq_req_o, 0);
        chk("R10 gie cleared", gie_o, 0);
        chk("R10 source flags cleared", {raised_o[id], pending_o[id]}, 0);
        acks++;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk("watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : driver
    int a;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 raised", raised_o, 0);
    chk("R1 pending", pending_o, 0);
    chk("R1 gie", gie_o, 0);
    chk("R1 request", irq_req_o, 0);

    // R2 R3: raise on a disabled source
    raise(bit_of(3));
    chk("R2 raised while disabled", raised_o[3], 1);
    chk("R3 not pending while disabled", pending_o[3], 0);

    // R4: source 0 is inert
    wr_en('1);
    raise(bit_of(0));
    chk("R4 source0 quiet", {raised_o[0], pending_o[0]}, 0);

    // R11 on a lone flag
    clr_flags(bit_of(3));
    chk("R11 flag cleared", raised_o[3], 0);

    // R7 R6 R12: three pending with gie off, then ordered service
    raise(bit_of(7) | bit_of(31) | bit_of(2));
    chk("R3 pending when enabled", pending_o, bit_of(7) | bit_of(31) | bit_of(2));
    repeat (10) @(negedge clk);
    chk("R7 no request while gie off", irq_req_o, 0);
    exp_q.push_back(16'd4);
    exp_q.push_back(16'd14);
    exp_q.push_back(16'd62);
    a = acks;
    gie_on();
    for (int k = 1; k <= 3; k++) begin
      wait_acks(a + k);
      do_reti();
      chk("R12 reti sets gie", gie_o, 1);
    end

    // R8 latency from idle with gie on
    repeat (4) @(negedge clk);
    exp_q.push_back(16'd18);
    a = acks;
    lat_arm = 1'b1;
    raise(bit_of(9));
    wait_acks(a + 1);
    do_reti();

    // R5 double raise
    gie_off();
    raise(bit_of(11));
    raise(bit_of(11));
    chk("R5 pending once", pending_o[11], 1);
    exp_q.push_back(16'd22);
    a = acks;
    gie_on();
    wait_acks(a + 1);
    do_reti();
    repeat (20) @(negedge clk);
    chk("R5 single service", acks, a + 1);
    chk("R5 queue empty", exp_q.size(), 0);

    // R9 dropped after disable
    gie_off();
    raise(bit_of(5) | bit_of(6));
    wr_en(~bit_of(5));
    exp_q.push_back(16'd12);
    a = acks;
    gie_on();
    wait_acks(a + 1);
    do_reti();
    repeat (10) @(negedge clk);
    chk("R9 dropped pending", pending_o[5], 0);
    chk("R9 raised kept", raised_o[5], 1);
    chk("R9 no extra service", acks, a + 1);

    // R11 clearing a pending request
    gie_off();
    wr_en('1);
    raise(bit_of(12) | bit_of(13));
    clr_flags(bit_of(12));
    chk("R11 cleared bit", {raised_o[12], pending_o[12]}, 0);
    chk("R11 neighbour untouched", {raised_o[13], pending_o[13]}, 2'b11);
    exp_q.push_back(16'd26);
    a = acks;
    gie_on();
    wait_acks(a + 1);
    do_reti();
    repeat (10) @(negedge clk);
    chk("R11 only survivor served", acks, a + 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule